// File: doc/BRIEF.md
# Registered Programmable-Logic Macrocell Array

This block models a small registered programmable logic array. A single-bit serial port loads a connection map into a programmable AND plane. Each of the eight macrocells ORs a fixed group of product terms and owns one flip-flop. A per-cell setting makes that flip-flop behave as a D type or a JK type. A second per-cell setting drives the pin from either the combinational sum or the register.

Every register output returns to the AND plane as a true literal and a complement literal. This lets the array build counters and state machines as well as plain logic. One global enable gates all pins. While the map is being loaded, the pins stay disabled and the registers hold their state. A synchronous reset clears both the map and the registers.

Top module: `rpal_array`

## Requirements
- R1: While `prog_en_i` is high, each rising clock edge shifts `prog_bit_i` into the top end (bit CFG_W-1) of the configuration vector and moves the other bits down by one. After CFG_W load cycles, the first bit shifted in sits at bit 0. When `prog_en_i` is low, the configuration does not change.
- R2: Macrocell m owns the slice starting at m*MC_W. Slice bit 0 selects the output source (1 = register, 0 = sum). Slice bit 1 selects the flip-flop type (1 = JK, 0 = D). The rest of the slice holds 2*N_PT masks of N_LIT bits each: masks 0..N_PT-1 form group A and masks N_PT..2*N_PT-1 form group B. In each mask, source s is enabled as a true literal by bit 2s and as a complement literal by bit 2s+1. Sources 0..N_IN-1 are the `in_i` bits and sources N_IN+k are register k. A product term is the AND of its enabled literals. A mask with no bits set gives 0.
- R3: The group A sum of a cell is the OR of its group A terms. A cell whose output source is the sum drives that value on its pin in the same cycle, with no clock.
- R4: A cell in D mode loads its group A sum on the rising clock edge and changes at no other time.
- R5: A cell in JK mode uses its group A sum as J and its group B sum as K. J=1, K=0 sets the register. J=0, K=1 clears it. J=K=1 toggles it. J=K=0 holds it.
- R6: A cell whose output source is the register shows its register value on its pin.
- R7: A register value is visible to every product term, as the true and complement literals of its own source, in the cycle after it changes.
- R8: `pin_oe_o` is all ones when `oe_i` is high and `prog_en_i` is low, and all zeros otherwise. Any pin whose enable is low reads 0.
- R9: While `prog_en_i` is high, every pin enable is 0 and no macrocell register changes.
- R10: When `rst_i` is high at a rising edge, every register and every configuration bit becomes 0. Reset takes priority over loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; registers and configuration update on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| in_i | input | N_IN | Dedicated logic inputs |
| oe_i | input | 1 | Global output enable, active high |
| prog_en_i | input | 1 | Configuration load enable |
| prog_bit_i | input | 1 | Serial configuration data |
| pin_o | output | N_MC | Pin values, 0 when disabled |
| pin_oe_o | output | N_MC | Per-pin drive enables |

## Verification
The hardest situations to reach are the ones that depend on register feedback through a chosen map: a JK toggle, a self-complementing D cell, or a sum that reads another cell's register. Random inputs alone almost never produce these. A directed map is therefore shifted in bit by bit, which also exercises the load path and the hold of the registers during loading. Input sequences then drive J=K=1, set, clear and feedback chains. Several random sparse maps follow, where each literal is enabled with low probability. This keeps product terms true often enough to matter and also produces empty and contradictory terms. A bench model predicts every pin in every cycle.

// File: rtl/rpal_pkg.sv
package rpal_pkg;

    // Per-macrocell header bits at the start of its configuration slice
    localparam int unsigned HDR_W    = 2;
    localparam int unsigned HDR_OSEL = 0;
    localparam int unsigned HDR_FFM  = 1;

    typedef enum logic {
        OSEL_SUM = 1'b0,
        OSEL_REG = 1'b1
    } osel_e;

    typedef enum logic {
        FFM_D  = 1'b0,
        FFM_JK = 1'b1
    } ffmode_e;

    typedef struct packed {
        logic q;
    } mc_state_t;

endpackage

// File: rtl/rpal_cfg_chain.sv
module rpal_cfg_chain #(
    parameter int unsigned CFG_W = 64
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [CFG_W-1:0] cfg_o
);

    typedef struct packed {
        logic [CFG_W-1:0] bits;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (rst_i) begin
            chain_d.bits = '0;
        end else if (shift_i) begin
            chain_d.bits = {bit_i, chain_q.bits[CFG_W-1:1]};
        end
    end

    always_ff @(posedge clk_i) begin
        chain_q <= chain_d;
    end

    assign cfg_o = chain_q.bits;

endmodule

// File: rtl/rpal_and_plane.sv
module rpal_and_plane #(
    parameter int unsigned N_LIT = 32,
    parameter int unsigned N_PT  = 4
) (
    input  logic [N_LIT-1:0]      lit_i,
    input  logic [N_PT*N_LIT-1:0] mask_i,
    output logic [N_PT-1:0]       term_o,
    output logic                  sum_o
);

    for (genvar p = 0; p < N_PT; p++) begin : g_term
        logic [N_LIT-1:0] msk;
        assign msk       = mask_i[p*N_LIT +: N_LIT];
        // empty mask gives 0; else all enabled literals must be 1
        assign term_o[p] = (|msk) & (&(lit_i | ~msk));
    end

    assign sum_o = |term_o;

endmodule

// File: rtl/rpal_macrocell.sv
module rpal_macrocell
    import rpal_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic hold_i,
    input  logic osel_i,
    input  logic ffm_i,
    input  logic sum_a_i,
    input  logic sum_b_i,
    output logic q_o,
    output logic val_o
);

    mc_state_t st_d, st_q;
    ffmode_e   mode;
    osel_e     osel;

    assign mode = ffmode_e'(ffm_i);
    assign osel = osel_e'(osel_i);

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.q = 1'b0;
        end else if (!hold_i) begin
            case (mode)
                FFM_JK:  st_d.q = (sum_a_i & ~st_q.q) | (~sum_b_i & st_q.q);
                default: st_d.q = sum_a_i;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign q_o   = st_q.q;
    assign val_o = (osel == OSEL_REG) ? st_q.q : sum_a_i;

endmodule

// File: rtl/rpal_array.sv
module rpal_array
    import rpal_pkg::*;
#(
    parameter int unsigned N_IN = 8,
    parameter int unsigned N_MC = 8,
    parameter int unsigned N_PT = 4
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [N_IN-1:0] in_i,
    input  logic            oe_i,
    input  logic            prog_en_i,
    input  logic            prog_bit_i,
    output logic [N_MC-1:0] pin_o,
    output logic [N_MC-1:0] pin_oe_o
);

    localparam int unsigned N_SRC = N_IN + N_MC;
    localparam int unsigned N_LIT = 2 * N_SRC;
    localparam int unsigned GRP_W = N_PT * N_LIT;
    localparam int unsigned MC_W  = HDR_W + 2 * GRP_W;
    localparam int unsigned CFG_W = N_MC * MC_W;

    logic [CFG_W-1:0] cfg_bits;
    logic [N_MC-1:0]  fb_q;
    logic [N_MC-1:0]  cell_val;
    logic [N_SRC-1:0] src;
    logic [N_LIT-1:0] lits;
    logic             drive_en;

    rpal_cfg_chain #(.CFG_W(CFG_W)) i_chain (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .shift_i (prog_en_i),
        .bit_i   (prog_bit_i),
        .cfg_o   (cfg_bits)
    );

    assign src = {fb_q, in_i};

    for (genvar s = 0; s < N_SRC; s++) begin : g_lit
        assign lits[2*s]   = src[s];
        assign lits[2*s+1] = ~src[s];
    end

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        logic [MC_W-1:0] slice;
        logic [N_PT-1:0] terms_a, terms_b;
        logic            sum_a, sum_b;

        assign slice = cfg_bits[m*MC_W +: MC_W];

        rpal_and_plane #(.N_LIT(N_LIT), .N_PT(N_PT)) i_grp_a (
            .lit_i  (lits),
            .mask_i (slice[HDR_W +: GRP_W]),
            .term_o (terms_a),
            .sum_o  (sum_a)
        );

        rpal_and_plane #(.N_LIT(N_LIT), .N_PT(N_PT)) i_grp_b (
            .lit_i  (lits),
            .mask_i (slice[HDR_W+GRP_W +: GRP_W]),
            .term_o (terms_b),
            .sum_o  (sum_b)
        );

        rpal_macrocell i_cell (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .hold_i  (prog_en_i),
            .osel_i  (slice[HDR_OSEL]),
            .ffm_i   (slice[HDR_FFM]),
            .sum_a_i (sum_a),
            .sum_b_i (sum_b),
            .q_o     (fb_q[m]),
            .val_o   (cell_val[m])
        );
    end

    assign drive_en = oe_i & ~prog_en_i;
    assign pin_oe_o = {N_MC{drive_en}};
    assign pin_o    = cell_val & pin_oe_o;

endmodule

// File: rtl/rpal_array_chk.sv
module rpal_array_chk #(
    parameter int unsigned N_MC = 8
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            oe_i,
    input logic            prog_en_i,
    input logic            prog_bit_i,
    input logic [N_MC-1:0] pin_o,
    input logic [N_MC-1:0] pin_oe_o,
    input logic [N_MC-1:0] fb_q,
    input logic            cfg_top
);

    // R10
    rst_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (fb_q == '0));

    // R9
    prog_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(prog_en_i) && !$past(rst_i)) |-> $stable(fb_q));

    // R9
    prog_oe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        prog_en_i |-> (pin_oe_o == '0));

    // R8
    oe_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !prog_en_i |-> (pin_oe_o == {N_MC{oe_i}}));

    // R8
    gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pin_o & ~pin_oe_o) == '0);

    // R1
    shift_in_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        prog_en_i |=> (cfg_top == $past(prog_bit_i)));

endmodule

bind rpal_array rpal_array_chk #(.N_MC(N_MC)) i_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .oe_i       (oe_i),
    .prog_en_i  (prog_en_i),
    .prog_bit_i (prog_bit_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o),
    .fb_q       (fb_q),
    .cfg_top    (cfg_bits[CFG_W-1])
);

// File: tb/test_rpal_array.sv
module test_rpal_array;

    localparam int N_IN   = 8;
    localparam int N_MC   = 8;
    localparam int N_PT   = 4;
    localparam int N_SRC  = N_IN + N_MC;
    localparam int N_LIT  = 2 * N_SRC;
    localparam int MC_W   = 2 + 2 * N_PT * N_LIT;
    localparam int CFG_W  = N_MC * MC_W;
    localparam int PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N_IN-1:0] in_v = '0;
    logic            oe = 1'b0;
    logic            prog = 1'b0;
    logic            pbit = 1'b0;
    logic [N_MC-1:0] pin, pin_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [CFG_W-1:0] mcfg;    // model configuration
    logic [N_MC-1:0]  mq;      // model registers
    logic [CFG_W-1:0] target;  // configuration to load

    always #(PERIOD/2) clk = ~clk;

    rpal_array #(.N_IN(N_IN), .N_MC(N_MC), .N_PT(N_PT)) i_rpal_array (
        .clk_i      (clk),
        .rst_i      (rst),
        .in_i       (in_v),
        .oe_i       (oe),
        .prog_en_i  (prog),
        .prog_bit_i (pbit),
        .pin_o      (pin),
        .pin_oe_o   (pin_oe)
    );

    // R2 group sum from the model configuration
    function automatic logic grp_sum(input logic [CFG_W-1:0] c, input int m, input int g,
                                     input logic [N_IN-1:0] inp, input logic [N_MC-1:0] q);
        logic s = 1'b0;
        for (int p = 0; p < N_PT; p++) begin
            logic any = 1'b0;
            logic all = 1'b1;
            int   base = m*MC_W + 2 + (g*N_PT + p)*N_LIT;
            for (int k = 0; k < N_SRC; k++) begin
                logic v = (k < N_IN) ? inp[k] : q[k-N_IN];
                if (c[base+2*k])   begin any = 1'b1; if (!v) all = 1'b0; end
                if (c[base+2*k+1]) begin any = 1'b1; if (v)  all = 1'b0; end
            end
            if (any && all) s = 1'b1;
        end
        return s;
    endfunction

    task automatic check(input string tag, input logic [N_MC-1:0] act, input logic [N_MC-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [N_IN-1:0] inp, input logic o, input logic pr,
                        input logic b, input logic r, input string tag);
        logic [N_MC-1:0] e_oe, e_pin, nq;
        @(negedge clk);
        in_v = inp; oe = o; prog = pr; pbit = b; rst = r;
        #1;
        e_oe = (o && !pr) ? '1 : '0;
        for (int m = 0; m < N_MC; m++) begin
            logic a  = grp_sum(mcfg, m, 0, inp, mq);
            logic kb = grp_sum(mcfg, m, 1, inp, mq);
            e_pin[m] = (mcfg[m*MC_W] ? mq[m] : a) & e_oe[m];
            nq[m]    = mcfg[m*MC_W+1] ? ((a & ~mq[m]) | (~kb & mq[m])) : a;
        end
        check({tag, " oe"}, pin_oe, e_oe);
        check({tag, " pin"}, pin, e_pin);
        @(posedge clk);
        if (r) begin
            mq = '0; mcfg = '0;
        end else if (pr) begin
            mcfg = {b, mcfg[CFG_W-1:1]};
        end else begin
            mq = nq;
        end
    endtask

    // R1 serial load, first bit ends at bit 0; R9 checked each load cycle
    task automatic load_cfg(input logic [CFG_W-1:0] c);
        for (int i = 0; i < CFG_W; i++)
            step(N_IN'($urandom), 1'b1, 1'b1, c[i], 1'b0, "R9");
    endtask

    task automatic set_lit(input int m, input int g, input int p, input int s, input bit neg);
        target[m*MC_W + 2 + (g*N_PT + p)*N_LIT + 2*s + (neg ? 1 : 0)] = 1'b1;
    endtask

    task automatic rand_cfg();
        for (int i = 0; i < CFG_W; i++) target[i] = ($urandom % 100) < 6;
        for (int m = 0; m < N_MC; m++) begin
            target[m*MC_W]   = $urandom % 2;
            target[m*MC_W+1] = $urandom % 2;
        end
    endtask

    initial begin
        void'($urandom(32'h5A17));
        mcfg = '0; mq = '0;
        repeat (2) @(posedge clk);
        // R10 reset state: cleared map, cleared registers
        step('0, 1'b1, 1'b0, 1'b0, 1'b0, "R10");

        // directed map
        target = '0;
        target[0*MC_W] = 1'b1;                       // mc0 D, registered, A = in0
        set_lit(0, 0, 0, 0, 0);
        target[1*MC_W] = 1'b1; target[1*MC_W+1] = 1'b1; // mc1 JK: J=in1 K=in2
        set_lit(1, 0, 0, 1, 0);
        set_lit(1, 1, 0, 2, 0);
        set_lit(2, 0, 0, 0, 0); set_lit(2, 0, 0, 1, 0);  // mc2 sum = in0&in1
        set_lit(2, 0, 1, 5, 0); set_lit(2, 0, 1, 5, 1);  // contradictory term
        target[3*MC_W] = 1'b1;                       // mc3 D self-complement
        set_lit(3, 0, 0, N_IN+3, 1);
        set_lit(4, 0, 0, N_IN+0, 0);                 // mc4 sum = q0
        load_cfg(target);
        step('0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        step(8'h01, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R6 R7");
        step(8'h06, 1'b1, 1'b0, 1'b0, 1'b0, "R5 toggle");
        step(8'h06, 1'b1, 1'b0, 1'b0, 1'b0, "R5 toggle");
        step(8'h06, 1'b1, 1'b0, 1'b0, 1'b0, "R5 toggle");
        step(8'h02, 1'b1, 1'b0, 1'b0, 1'b0, "R5 set");
        step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R5 hold");
        step(8'h04, 1'b1, 1'b0, 1'b0, 1'b0, "R5 clear");
        step(8'h03, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        step(8'h01, 1'b1, 1'b0, 1'b0, 1'b0, "R2 R3");
        step(8'h03, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
        step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 40; i++)
            step(N_IN'($urandom), ($urandom % 8) != 0, 1'b0, 1'b0, 1'b0, "R3 R4 R5 R6 R7");
        // R9 hold: a few load cycles with registers set
        for (int i = 0; i < 4; i++)
            step(N_IN'($urandom), 1'b1, 1'b1, 1'b0, 1'b0, "R9");
        step('0, 1'b1, 1'b0, 1'b0, 1'b0, "R9 after");

        // random sparse maps
        for (int t = 0; t < 5; t++) begin
            rand_cfg();
            load_cfg(target);
            for (int i = 0; i < 150; i++)
                step(N_IN'($urandom), ($urandom % 8) != 0, 1'b0, 1'b0, 1'b0, "R2 R3 R4 R5 R6 R7");
        end

        // R10 reset in mid-run, and reset wins over load
        step(N_IN'($urandom), 1'b1, 1'b1, 1'b1, 1'b1, "R10");
        step('0, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
        step('1, 1'b1, 1'b0, 1'b0, 1'b0, "R10");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule